// File: doc/BRIEF.md
# Oversampled Serial Bit Recovery

This block takes a serial line that has already been turned into one bit per sample (by a comparator ahead of it) and sampled at a fixed integer multiple of the bit rate. With the defaults, the line carries 600 bit/s and is sampled at 3000 samples/s, so each bit spans five samples. The block follows the bit boundaries from the line's own level changes. It takes one decision sample near the centre of each bit and emits the recovered bit with a one-cycle valid strobe.

A second stage watches the recovered bits for a known 8-bit word that is sent back to back, 8'b01011010 by default. It finds the alignment of that word in the stream and reports lock. While locked, it marks each word boundary and reports when lock is lost. Recovered bits are shifted in oldest-first, so the newest bit sits at bit 0 of the compared word. Because the default word reads the same in either direction, the transmit bit order does not matter. After a loss, the search restarts by itself, so alignment comes back on later words without a reset.

The phase tracker is a counter that wraps modulo the oversampling ratio and is cleared on every transition. The alignment stage is a state machine with four states:
- SEARCH moves to CONFIRM on any match.
- CONFIRM moves to LOCKED on a match exactly one word later, or back to SEARCH on a mismatch at that boundary.
- LOCKED stays put on a boundary match, or moves to SUSPECT on a boundary mismatch.
- SUSPECT returns to LOCKED on a boundary match, or falls to SEARCH on a second consecutive boundary mismatch.

Top module: `serial_bit_recovery`

## Requirements
- R1: Reset is synchronous and active-high. While it is held and on the first cycle after it, `bit_valid`, `locked`, `word_start` and `lock_lost` are 0, and any lock held before reset is cleared.
- R2: When an enabled sample differs from the previous enabled sample, the phase count restarts at 0 on that sample. The enabled sample at phase index OSR/2 (index 2 for OSR=5) is output as `bit_out`, with `bit_valid` high for exactly the one clock cycle after that sample's enable cycle.
- R3: During runs of equal level the phase count keeps wrapping, so one bit is emitted for every OSR enabled samples and a run of N bits gives N recovered bits.
- R4: The recovered bit sequence equals the sent sequence when individual bits last OSR-1, OSR or OSR+1 samples, because every transition re-centres the sampling phase.
- R5: Cycles with `samp_en` low are ignored. The level of `samp_in` in those cycles changes neither the phase nor the recovered bits.
- R6: Lock is declared on the recovered bit that completes a second match of the word exactly 8 bits after a first match. `locked` rises and `word_start` pulses in the cycle after that bit's `bit_valid`.
- R7: While locked, `word_start` pulses once every 8 recovered bits, one cycle after the `bit_valid` of each boundary bit. `word_start` never pulses while unlocked.
- R8: A single boundary mismatch while locked does not drop lock, and `word_start` keeps its 8-bit spacing.
- R9: Two consecutive boundary mismatches drop `locked` and give a one-cycle `lock_lost` pulse at the second mismatching boundary. The search then restarts.
- R10: Alignment is found at any bit offset of the stream, and it is found again after a loss, without reset. The first `word_start` comes 16 bits after the first full word in the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Marks a cycle holding a new line sample |
| samp_in | input | 1 | Thresholded line sample |
| bit_valid | output | 1 | One-cycle strobe for a recovered bit |
| bit_out | output | 1 | Recovered bit value, valid with bit_valid |
| locked | output | 1 | Word alignment is held |
| word_start | output | 1 | Pulse at each aligned word boundary |
| lock_lost | output | 1 | Pulse when alignment is dropped |

## Verification
The bench builds the block with its defaults: five samples per bit and the 8-bit word 01011010. With these values, a few dozen bits reach every alignment state and every transition, including a rotated start, one bad word inside lock, and two bad words in a row. Because five samples per bit leaves one sample of slack on each side of the centre, bit lengths of four to six samples can check drift tolerance. Disabled cycles carrying the inverted level test that the sample enable really gates the input.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [1:0] {
        AL_SEARCH  = 2'd0,
        AL_CONFIRM = 2'd1,
        AL_LOCKED  = 2'd2,
        AL_SUSPECT = 2'd3
    } align_state_t;
endpackage

// File: rtl/sbr_phase_track.sv
module sbr_phase_track #(
    parameter int OSR = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic samp_in,
    output logic bit_valid,
    output logic bit_out
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
    localparam logic [CW-1:0] PH_LAST   = CW'(OSR - 1);
    localparam logic [CW-1:0] PH_CENTER = CW'(OSR / 2);

    logic          prev_q;
    logic [CW-1:0] ph_q;
    logic [CW-1:0] ph_nx;
    logic          edge_seen;

    always_comb begin
        edge_seen = (samp_in != prev_q);
        if (edge_seen)
            ph_nx = '0;
        else if (ph_q == PH_LAST)
            ph_nx = '0;
        else
            ph_nx = ph_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= 1'b0;
            ph_q      <= '0;
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            if (samp_en) begin
                prev_q <= samp_in;
                ph_q   <= ph_nx;
                if (ph_nx == PH_CENTER) begin
                    bit_valid <= 1'b1;
                    bit_out   <= samp_in;
                end
            end
        end
    end

    // R2: a transition restarts the phase
    p_edge_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (samp_en && (samp_in != prev_q)) |=> (ph_q == '0));
    // R3: phase never leaves its range
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ph_q <= PH_LAST);
    // R5: a strobe only follows an enabled sample
    p_valid_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(samp_en));
endmodule

// File: rtl/sbr_word_align.sv
module sbr_word_align
    import sbr_pkg::*;
#(
    parameter int              WORD_W  = 8,
    parameter logic [WORD_W-1:0] PATTERN = 8'b01011010
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic locked,
    output logic word_start,
    output logic lock_lost
);
    localparam int BCW = $clog2(WORD_W);
    localparam logic [BCW-1:0] B_LAST = BCW'(WORD_W - 1);

    align_state_t      st_q, st_nx;
    logic [WORD_W-1:0] sr_q, sr_nx;
    logic [BCW-1:0]    bcnt_q;
    logic              match, at_bnd;

    always_comb begin
        sr_nx  = {sr_q[WORD_W-2:0], bit_in};
        match  = (sr_nx == PATTERN);
        at_bnd = (bcnt_q == B_LAST);
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (bit_valid) begin
            unique case (st_q)
                AL_SEARCH:  if (match) st_nx = AL_CONFIRM;
                AL_CONFIRM: if (at_bnd) st_nx = match ? AL_LOCKED : AL_SEARCH;
                AL_LOCKED:  if (at_bnd && !match) st_nx = AL_SUSPECT;
                AL_SUSPECT: if (at_bnd) st_nx = match ? AL_LOCKED : AL_SEARCH;
                default:    st_nx = AL_SEARCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= AL_SEARCH;
        else     st_q <= st_nx;
    end

    // word shift register and boundary counter
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (bit_valid) begin
            sr_q <= sr_nx;
            if (st_q == AL_SEARCH || at_bnd)
                bcnt_q <= '0;
            else
                bcnt_q <= bcnt_q + BCW'(1);
        end
    end

    // registered pulse outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            word_start <= 1'b0;
            lock_lost  <= 1'b0;
        end else begin
            word_start <= 1'b0;
            lock_lost  <= 1'b0;
            if (bit_valid && at_bnd && st_q != AL_SEARCH) begin
                word_start <= (st_nx == AL_LOCKED) || (st_nx == AL_SUSPECT);
                lock_lost  <= (st_q == AL_SUSPECT) && (st_nx == AL_SEARCH);
            end
        end
    end

    assign locked = (st_q == AL_LOCKED) || (st_q == AL_SUSPECT);

    // R6: lock always starts with a boundary mark
    p_lock_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> word_start);
    // R7: no boundary mark without lock
    p_ws_locked_r7: assert property (@(posedge clk) disable iff (rst)
        word_start |-> locked);
    // R9: loss pulse follows a locked cycle and leaves lock dropped
    p_lost_drop_r9: assert property (@(posedge clk) disable iff (rst)
        lock_lost |-> (!locked && $past(locked)));
    // R9: loss and boundary pulses never coincide
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_start, lock_lost}));
endmodule

// File: rtl/serial_bit_recovery.sv
module serial_bit_recovery #(
    parameter int                OSR     = 5,
    parameter int                WORD_W  = 8,
    parameter logic [WORD_W-1:0] PATTERN = 8'b01011010
) (
    input  logic clk,
    input  logic rst,
    input  logic samp_en,
    input  logic samp_in,
    output logic bit_valid,
    output logic bit_out,
    output logic locked,
    output logic word_start,
    output logic lock_lost
);
    sbr_phase_track #(.OSR(OSR)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .samp_en  (samp_en),
        .samp_in  (samp_in),
        .bit_valid(bit_valid),
        .bit_out  (bit_out)
    );

    sbr_word_align #(.WORD_W(WORD_W), .PATTERN(PATTERN)) u_align (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_out),
        .locked    (locked),
        .word_start(word_start),
        .lock_lost (lock_lost)
    );

    // R1: outputs quiet on the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bit_valid && !locked && !word_start && !lock_lost));
endmodule

// File: tb/tb_serial_bit_recovery.sv
module tb_serial_bit_recovery;
    localparam int CLK_PERIOD = 10;
    localparam int OSR = 5;
    localparam logic [7:0] WORD = 8'b01011010;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic samp_en = 1'b0;
    logic samp_in = 1'b0;
    logic bit_valid, bit_out, locked, word_start, lock_lost;

    serial_bit_recovery dut (
        .clk(clk), .rst(rst), .samp_en(samp_en), .samp_in(samp_in),
        .bit_valid(bit_valid), .bit_out(bit_out), .locked(locked),
        .word_start(word_start), .lock_lost(lock_lost)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic tx [0:511];
    int tx_n = 0;
    logic rx [0:511];
    int rx_n = 0;
    int ws_pos [0:63];
    int ws_n = 0;
    int lost_pos [0:63];
    int lost_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (word_start && ws_n < 64) begin ws_pos[ws_n] = rx_n; ws_n++; end
            if (lock_lost && lost_n < 64) begin lost_pos[lost_n] = rx_n; lost_n++; end
            if (bit_valid && rx_n < 512) begin rx[rx_n] = bit_out; rx_n++; end
        end
    end

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary_and_end();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; samp_en = 1'b0; samp_in = 1'b0;
        repeat (3) @(negedge clk);
        tx_n = 0; rx_n = 0; ws_n = 0; lost_n = 0;
        rst = 1'b0;
    endtask

    task automatic add_word(input logic [7:0] w);
        for (int b = 7; b >= 0; b--) begin tx[tx_n] = w[b]; tx_n++; end
    endtask

    task automatic add_bit(input logic v);
        tx[tx_n] = v; tx_n++;
    endtask

    // mode 0: OSR samples per bit; 1: 4/5/6 samples; 2: gaps with inverted noise
    task automatic send_stream(input int mode);
        for (int i = 0; i < tx_n; i++) begin
            int len;
            len = (mode == 1) ? (4 + (i % 3)) : OSR;
            for (int s = 0; s < len; s++) begin
                if (mode == 2) begin
                    @(negedge clk); samp_en = 1'b0; samp_in = ~tx[i];
                end
                @(negedge clk); samp_en = 1'b1; samp_in = tx[i];
            end
        end
        @(negedge clk); samp_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic cmp_bits(input string req);
        int bad;
        bad = -1;
        chk(req, rx_n, tx_n);
        for (int i = 0; i < tx_n && i < rx_n; i++)
            if (bad < 0 && rx[i] != tx[i]) bad = i;
        if (bad >= 0)
            $display("FAIL %s: bit %0d actual %0d expected %0d", req, bad, rx[bad], tx[bad]);
        n_chk++;
        if (bad >= 0) n_fail++;
    endtask

    task automatic t_reset_state();
        rst = 1'b1; samp_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 valid in reset", int'(bit_valid), 0);
        chk("R1 locked in reset", int'(locked), 0);
        chk("R1 word_start in reset", int'(word_start), 0);
        chk("R1 lock_lost in reset", int'(lock_lost), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 locked after reset", int'(locked), 0);
    endtask

    task automatic t_center();
        int first_hit;
        do_reset();
        first_hit = -1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (bit_valid && first_hit < 0) first_hit = k - 1;
            samp_en = 1'b1; samp_in = 1'b1;
        end
        samp_en = 1'b0;
        chk("R2 centre sample index", first_hit, OSR / 2);
    endtask

    task automatic t_aligned();
        do_reset();
        for (int w = 0; w < 4; w++) add_word(WORD);
        send_stream(0);
        cmp_bits("R2 aligned bits");
        chk("R6 boundary count", ws_n, 3);
        chk("R6 first lock bit", ws_pos[0], 16);
        chk("R7 second boundary", ws_pos[1], 24);
        chk("R7 third boundary", ws_pos[2], 32);
        chk("R7 locked at end", int'(locked), 1);
    endtask

    task automatic t_runs();
        do_reset();
        for (int i = 0; i < 4; i++) add_bit(1'b0);
        for (int i = 0; i < 6; i++) add_bit(1'b1);
        for (int i = 0; i < 3; i++) add_bit(1'b0);
        add_bit(1'b1);
        send_stream(0);
        cmp_bits("R3 long runs");
    endtask

    task automatic t_drift();
        do_reset();
        for (int w = 0; w < 3; w++) add_word(WORD);
        send_stream(1);
        cmp_bits("R4 drifting bit lengths");
    endtask

    task automatic t_enable();
        do_reset();
        for (int w = 0; w < 3; w++) add_word(WORD);
        send_stream(2);
        cmp_bits("R5 disabled cycles ignored");
        chk("R5 lock with gaps", ws_pos[0], 16);
    endtask

    task automatic t_offset();
        do_reset();
        add_bit(1'b1); add_bit(1'b1); add_bit(1'b0);
        for (int w = 0; w < 3; w++) add_word(WORD);
        send_stream(0);
        chk("R10 offset boundary count", ws_n, 2);
        chk("R10 offset first lock", ws_pos[0], 19);
        chk("R10 offset next boundary", ws_pos[1], 27);
    endtask

    task automatic t_single_miss();
        do_reset();
        for (int w = 0; w < 3; w++) add_word(WORD);
        add_word(8'h00);
        for (int w = 0; w < 2; w++) add_word(WORD);
        send_stream(0);
        chk("R8 no loss", lost_n, 0);
        chk("R8 boundary count", ws_n, 5);
        chk("R8 mark on bad word", ws_pos[2], 32);
        chk("R8 mark after bad word", ws_pos[3], 40);
        chk("R8 still locked", int'(locked), 1);
    endtask

    task automatic t_loss();
        do_reset();
        for (int w = 0; w < 3; w++) add_word(WORD);
        add_word(8'h00); add_word(8'h00);
        for (int w = 0; w < 3; w++) add_word(WORD);
        send_stream(0);
        chk("R9 loss count", lost_n, 1);
        chk("R9 loss position", lost_pos[0], 40);
        chk("R10 relock boundary count", ws_n, 5);
        chk("R10 relock position", ws_pos[3], 56);
        chk("R10 relocked", int'(locked), 1);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_center();
        t_aligned();
        t_runs();
        t_drift();
        t_enable();
        t_offset();
        t_single_miss();
        t_loss();
        t_reset_state();
        summary_and_end();
    end
endmodule